// File: doc/BRIEF.md
# Serial Frame Delimiter Hunter and Byte Capture

This block watches a serial line that carries one bit per clock. It searches for a fixed 64-bit start delimiter. The delimiter is the pair 1,1 followed by thirty-one 0,1 pairs. After the last delimiter bit it enters a capture state. In that state it packs each following bit into bytes and marks every finished byte with a strobe. The capture state lasts until the frame-valid qualifier drops from 1 to 0. The block then gives a one-clock end-of-frame commit pulse and goes back to searching.

The search does not use a 64-input comparator. A bit index steps through the delimiter one received bit at a time. The qualifier often rises partway through the delimiter, so matching runs whether the qualifier is high or low. The qualifier must be synchronous to the clock. An asynchronous source needs a synchronizer in front of this block.

The controller has three states:
- SEEK: the index is zero.
- TRACK: part of the delimiter has matched.
- CAPTURE: the block is collecting payload.

The transitions are:
- SEEK→TRACK: the bit equals the first delimiter bit.
- SEEK→SEEK: any other bit.
- TRACK→TRACK (step): a matching bit that is not the last delimiter bit.
- TRACK→TRACK (restart): a mismatching bit that is a 1, so the index becomes 1.
- TRACK→SEEK: a mismatching bit that is a 0.
- TRACK→CAPTURE: a match on the final delimiter bit.
- CAPTURE→CAPTURE: the bit is taken as payload.
- CAPTURE→SEEK: a falling qualifier edge is seen.

Top module: `serial_frame_capture`

## Requirements
- R1: While reset is asserted and after it is released, `in_frame`, `byte_stb` and `frame_end` are 0 and `byte_data` is 0x00.
- R2: The delimiter is matched in transmission order, with the first received bit checked against the leftmost bit of 1,1,(0,1)×31. `in_frame` goes high on the clock edge that samples the final delimiter bit.
- R3: Delimiter matching ignores `frame_ok`. A delimiter sent with the qualifier low for all 64 bits still starts capture, and its payload bytes are still assembled.
- R4: On a mismatch the partial match is dropped. The same bit is then compared with the first delimiter bit (a 1). A mismatching 1 restarts the index at 1, so the remaining 63 delimiter bits then complete a match. A mismatching 0 returns to SEEK.
- R5: Capture starts with the bit after the final delimiter bit. Bits are packed first-received into bit 0. `byte_stb` is high for one clock after the edge that samples each eighth payload bit, and `byte_data` holds that byte until the next one is complete.
- R6: In CAPTURE, when `frame_ok` is sampled 0 one edge after it was sampled 1, that edge does three things: it drops `in_frame`, it raises `frame_end` for exactly one clock, and it returns the block to SEEK.
- R7: The bit sampled on the falling-qualifier edge is not payload. A partial byte held at frame end is discarded with no strobe, and the next frame packs from bit 0.
- R8: A falling qualifier edge outside CAPTURE produces no `frame_end`.
- R9: Searching resumes on the bit right after the frame-end edge, so a delimiter that starts on that bit is found.
- R10: During CAPTURE a delimiter in the payload is treated as data. `in_frame` stays high.
- R11: Asserting `rst_n` low mid-frame clears `in_frame` at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Serial data bit |
| frame_ok | input | 1 | Frame-valid qualifier, synchronous |
| in_frame | output | 1 | High while payload is being captured |
| byte_data | output | BYTE_W | Last completed payload byte |
| byte_stb | output | 1 | One-clock pulse marking a new `byte_data` |
| frame_end | output | 1 | One-clock end-of-frame commit pulse |

## Verification
Every result is due one edge after its stimulus:
- `in_frame` rises on the edge that samples the last delimiter bit.
- `byte_stb` and `byte_data` update on the edge that samples the eighth payload bit.
- `frame_end` rises and `in_frame` falls on the edge where the qualifier is sampled low after being sampled high.

The bench drives each bit on the falling clock edge. It steps a bench-side model of the requirements by one bit at the same time, then samples the outputs 2 ns after the next rising edge, so a result is compared in exactly the cycle it is due. The only exception is the asynchronous reset case, which is sampled 1 ns after `rst_n` drops, with no edge in between.

// File: rtl/frame_cap_pkg.sv
package frame_cap_pkg;

    typedef enum logic [1:0] {
        ST_SEEK    = 2'd0,
        ST_TRACK   = 2'd1,
        ST_CAPTURE = 2'd2
    } hunt_state_t;

    typedef enum logic [1:0] {
        IDX_HOLD  = 2'd0,
        IDX_CLEAR = 2'd1,
        IDX_STEP  = 2'd2,
        IDX_FIRST = 2'd3
    } idx_op_t;

endpackage

// File: rtl/valid_fall_det.sv
module valid_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // high in the cycle where the level is low after a high cycle
    assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/delim_walker.sv
module delim_walker
    import frame_cap_pkg::*;
#(
    parameter int          LEN     = 64,
    parameter logic [LEN-1:0] PATTERN = 64'hD555_5555_5555_5555
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bit_in,
    input  idx_op_t op,
    output logic    bit_ok,
    output logic    first_ok,
    output logic    at_last
);
    localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [IDX_W-1:0] TOP = IDX_W'(LEN - 1);

    logic [IDX_W-1:0] idx_q;
    logic             expect_bit;

    // transmission order: index 0 is the leftmost (most significant) pattern bit
    assign expect_bit = PATTERN[TOP - idx_q];
    assign bit_ok     = (bit_in == expect_bit);
    assign first_ok   = (bit_in == PATTERN[LEN-1]);
    assign at_last    = (idx_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            unique case (op)
                IDX_HOLD:  idx_q <= idx_q;
                IDX_CLEAR: idx_q <= '0;
                IDX_STEP:  idx_q <= idx_q + IDX_W'(1);
                IDX_FIRST: idx_q <= IDX_W'(1);
                default:   idx_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/byte_packer.sv
module byte_packer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         take,
    input  logic         bit_in,
    output logic [W-1:0] data_out,
    output logic         stb
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shadow_q <= '0;
            data_out <= '0;
            stb      <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (flush) begin
                cnt_q <= '0;
            end else if (take) begin
                for (int k = 0; k < W; k++) begin
                    if (cnt_q == CW'(k)) shadow_q[k] <= bit_in;
                end
                if (cnt_q == LAST) begin
                    data_out <= {bit_in, shadow_q[W-2:0]};
                    stb      <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/serial_frame_capture.sv
module serial_frame_capture
    import frame_cap_pkg::*;
#(
    parameter int               DELIM_LEN = 64,
    parameter logic [DELIM_LEN-1:0] DELIM = 64'hD555_5555_5555_5555,
    parameter int               BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              frame_ok,
    output logic              in_frame,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_stb,
    output logic              frame_end
);
    hunt_state_t state_q, state_d;
    idx_op_t     op;
    logic        fall, bit_ok, first_ok, at_last, take;

    valid_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (frame_ok),
        .fall  (fall)
    );

    delim_walker #(.LEN(DELIM_LEN), .PATTERN(DELIM)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (ser_bit),
        .op       (op),
        .bit_ok   (bit_ok),
        .first_ok (first_ok),
        .at_last  (at_last)
    );

    byte_packer #(.W(BYTE_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (state_q != ST_CAPTURE),
        .take     (take),
        .bit_in   (ser_bit),
        .data_out (byte_data),
        .stb      (byte_stb)
    );

    always_comb begin
        state_d = state_q;
        op      = IDX_HOLD;
        take    = 1'b0;
        unique case (state_q)
            ST_SEEK: begin
                if (first_ok) begin
                    state_d = ST_TRACK;
                    op      = IDX_FIRST;
                end else begin
                    op = IDX_CLEAR;
                end
            end
            ST_TRACK: begin
                if (bit_ok) begin
                    if (at_last) begin
                        state_d = ST_CAPTURE;
                        op      = IDX_CLEAR;
                    end else begin
                        op = IDX_STEP;
                    end
                end else if (first_ok) begin
                    op = IDX_FIRST;
                end else begin
                    state_d = ST_SEEK;
                    op      = IDX_CLEAR;
                end
            end
            ST_CAPTURE: begin
                if (fall) state_d = ST_SEEK;
                else      take    = 1'b1;
            end
            default: begin
                state_d = ST_SEEK;
                op      = IDX_CLEAR;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_end <= 1'b0;
        else        frame_end <= (state_q == ST_CAPTURE) && fall;
    end

    assign in_frame = (state_q == ST_CAPTURE);
endmodule

// File: rtl/frame_capture_chk.sv
module frame_capture_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_bit,
    input logic frame_ok,
    input logic in_frame,
    input logic byte_stb,
    input logic frame_end
);
    // R6
    end_drops_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !in_frame);

    // R6
    end_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R6
    fall_gives_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && $past(frame_ok) && !frame_ok) |=> frame_end);

    // R8
    no_end_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |=> !frame_end);

    // R2
    last_delim_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> $past(ser_bit));

    // R5
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);

    // R5
    strobe_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(in_frame));

    // R7
    no_strobe_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !byte_stb);
endmodule

bind serial_frame_capture frame_capture_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_bit   (ser_bit),
    .frame_ok  (frame_ok),
    .in_frame  (in_frame),
    .byte_stb  (byte_stb),
    .frame_end (frame_end)
);

// File: tb/sim_serial_frame_capture.sv
`timescale 1ns/1ps
module sim_serial_frame_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       frame_ok = 1'b0;
    logic       in_frame, byte_stb, frame_end;
    logic [7:0] byte_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state
    int         m_st = 0;
    int         m_idx = 0;
    int         m_cnt = 0;
    logic       m_vq = 0;
    logic [7:0] m_buf = 0;
    logic [7:0] m_byte = 0;
    logic       m_stb = 0;
    logic       m_end = 0;

    always #4 clk = ~clk;

    serial_frame_capture u0 (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .frame_ok(frame_ok),
        .in_frame(in_frame), .byte_data(byte_data), .byte_stb(byte_stb),
        .frame_end(frame_end)
    );

    function automatic logic pat(input int i);
        if (i < 2) return 1'b1;
        return (i % 2 == 1) ? 1'b1 : 1'b0;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_idx = 0; m_cnt = 0; m_vq = 0;
        m_buf = 0; m_byte = 0; m_stb = 0; m_end = 0;
    endtask

    task automatic model_step(input logic b, input logic v);
        logic fall;
        fall  = m_vq && !v;
        m_end = (m_st == 2) && fall;
        m_stb = 0;
        case (m_st)
            0: if (b == pat(0)) begin m_idx = 1; m_st = 1; end
            1: begin
                if (b == pat(m_idx)) begin
                    if (m_idx == 63) begin m_st = 2; m_idx = 0; m_cnt = 0; end
                    else m_idx++;
                end else if (b == pat(0)) m_idx = 1;
                else begin m_idx = 0; m_st = 0; end
            end
            default: begin
                if (fall) begin m_st = 0; m_cnt = 0; end
                else begin
                    m_buf[m_cnt] = b;
                    if (m_cnt == 7) begin m_byte = m_buf; m_stb = 1; m_cnt = 0; end
                    else m_cnt++;
                end
            end
        endcase
        m_vq = v;
    endtask

    task automatic tick(input logic b, input logic v);
        @(negedge clk);
        ser_bit  = b;
        frame_ok = v;
        model_step(b, v);
        @(posedge clk);
        #2;
        check("R2 in_frame", {31'd0, in_frame}, {31'd0, m_st == 2});
        check("R5 byte_stb", {31'd0, byte_stb}, {31'd0, m_stb});
        check("R5 byte_data", {24'd0, byte_data}, {24'd0, m_byte});
        check("R6 frame_end", {31'd0, frame_end}, {31'd0, m_end});
    endtask

    task automatic send_delim(input int rise);
        for (int i = 0; i < 64; i++) tick(pat(i), i >= rise);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic v);
        for (int j = 0; j < 8; j++) tick(d[j], v);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        // R1 reset state
        #10;
        check("R1 in_frame in reset", {31'd0, in_frame}, 0);
        check("R1 byte_stb in reset", {31'd0, byte_stb}, 0);
        check("R1 frame_end in reset", {31'd0, frame_end}, 0);
        check("R1 byte_data in reset", {24'd0, byte_data}, 0);
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b0);
        check("R1 in_frame after reset", {31'd0, in_frame}, 0);

        // R2 / R5 / R6 / R7: valid rises mid-delimiter
        send_delim(30);
        check("R2 in_frame after delimiter", {31'd0, in_frame}, 1);
        send_byte(8'hA5, 1'b1);
        check("R5 first byte", {24'd0, byte_data}, 32'hA5);
        check("R5 first strobe", {31'd0, byte_stb}, 1);
        send_byte(8'h3C, 1'b1);
        check("R5 second byte", {24'd0, byte_data}, 32'h3C);
        tick(1'b1, 1'b1); tick(1'b0, 1'b1); tick(1'b1, 1'b1);
        tick(1'b1, 1'b0);
        check("R6 frame_end pulse", {31'd0, frame_end}, 1);
        check("R6 in_frame dropped", {31'd0, in_frame}, 0);
        check("R7 partial byte no strobe", {31'd0, byte_stb}, 0);
        tick(1'b0, 1'b0);
        check("R6 frame_end one cycle", {31'd0, frame_end}, 0);

        // R8: qualifier falls outside capture
        tick(1'b0, 1'b1); tick(1'b0, 1'b0);
        check("R8 no frame_end outside capture", {31'd0, frame_end}, 0);

        // R3: valid low through whole delimiter
        send_delim(64);
        check("R3 capture without qualifier", {31'd0, in_frame}, 1);
        for (int j = 0; j < 8; j++) tick(j < 4, j >= 4);
        check("R3 byte assembled", {24'd0, byte_data}, 32'h0F);
        tick(1'b1, 1'b0);
        check("R6 end after late qualifier", {31'd0, frame_end}, 1);

        // R9: delimiter starts on the very next bit; R10 delimiter in payload
        send_delim(0);
        check("R9 back-to-back delimiter", {31'd0, in_frame}, 1);
        tick(1'b0, 1'b1); tick(1'b1, 1'b1); tick(1'b1, 1'b1);
        send_delim(0);
        check("R10 payload delimiter ignored", {31'd0, in_frame}, 1);
        tick(1'b0, 1'b0);
        // R7: next frame packs from bit 0 (3+64 bits left a partial byte)
        send_delim(0);
        send_byte(8'h81, 1'b1);
        check("R7 fresh packing", {24'd0, byte_data}, 32'h81);
        tick(1'b0, 1'b0);

        // R4: mismatching 1 restarts at index 1
        tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) tick(pat(i), 1'b1);
        tick(1'b1, 1'b1);
        for (int i = 1; i < 64; i++) tick(pat(i), 1'b1);
        check("R4 restart after mismatching 1", {31'd0, in_frame}, 1);
        tick(1'b0, 1'b0);
        // R4: mismatching 0 returns to seek
        tick(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) tick(pat(i), 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 1; i < 64; i++) tick(pat(i), 1'b0);
        check("R4 no match after mismatching 0", {31'd0, in_frame}, 0);

        // R11: asynchronous reset mid-frame
        send_delim(10);
        tick(1'b1, 1'b1); tick(1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 async clear in_frame", {31'd0, in_frame}, 0);
        check("R11 async clear byte_data", {24'd0, byte_data}, 0);
        frame_ok = 1'b0;
        model_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // random frames
        for (int f = 0; f < 40; f++) begin
            int noise, rise, len;
            noise = $urandom % 20;
            rise  = $urandom % 64;
            len   = $urandom % 40;
            for (int i = 0; i < noise; i++) tick(1'($urandom % 2), 1'b0);
            send_delim(rise);
            for (int i = 0; i < len; i++) tick(1'($urandom % 2), 1'b1);
            tick(1'($urandom % 2), 1'b0);
            for (int i = 0; i < int'($urandom % 4); i++) tick(1'($urandom % 2), 1'b0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule